// File: doc/BRIEF.md
# Ring Trip Detector

This block confirms that a telephone set has gone off-hook while its line is being rung. It takes a stream of digitized loop-current samples, each marked by a valid strobe, plus a flag that says the line is in the ringing state. While ringing is active, each sample moves a first-order low-pass filter one step. The filter removes the AC ringing component from the current. The new filtered value is compared against a programmable threshold. The result of that comparison feeds a debouncer that holds its output until the comparison has held the opposite value for a programmed number of consecutive samples.

When the debounced output rises, the block sets a sticky trip status bit. That bit also acts as the pending interrupt flag, and it drives a level interrupt when the interrupt enable is set. The filter coefficient, threshold, debounce length, interrupt enable and status clear are all plain input ports. Leaving the ringing state empties the filter and resets the debouncer. The status bit survives until software clears it.

Top module: `ring_trip_detector`

## Requirements
- R1: A synchronous active-high reset clears the filtered value, the debounced trip level, the trip status and the interrupt to zero.
- R2: On each clock edge where `sampleValid` and `ringActive` are both high, the filtered value y becomes y + floor(((x - y) * coef) / 256). Here x is the 16-bit unsigned sample and coef is the 8-bit unsigned coefficient. On all other edges while ringing, y holds.
- R3: The comparator is true only when the newly filtered value is strictly greater than `tripThresh`. A filtered value equal to the threshold counts as below.
- R4: With debounce length N, `tripLevel` rises on the (N+1)-th consecutive sample strobe whose comparison is true. Any strobe whose comparison matches the current `tripLevel` restarts the count. With N = 0 the level follows on the first opposite strobe.
- R5: Release is symmetric. A high `tripLevel` falls only on the (N+1)-th consecutive strobe whose comparison is false.
- R6: While `ringActive` is low, the filtered value, the debounce count and `tripLevel` are held at zero. Sample strobes in that state have no effect on them.
- R7: A rising `tripLevel` sets `tripStatus`. `tripStatus` stays set, including across the end of ringing, until a `statusClear` pulse. If a set and a clear fall on the same edge, the set wins.
- R8: `tripIrq` is high exactly when `tripStatus` is set and `irqEnable` is high. A trip that is latched while the interrupt is disabled raises `tripIrq` as soon as the interrupt is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ringActive | input | 1 | Line is in the ringing state |
| sampleValid | input | 1 | Strobe marking a new loop-current sample |
| sampleData | input | 16 | Unsigned loop-current sample |
| filtCoef | input | 8 | Low-pass coefficient, gain coef/256 per step |
| tripThresh | input | 16 | Trip threshold for the filtered value |
| debounceLen | input | 7 | Debounce length N in sample strobes |
| irqEnable | input | 1 | Interrupt enable |
| statusClear | input | 1 | One-cycle pulse that clears the sticky status |
| filtOut | output | 16 | Current filtered loop current |
| tripLevel | output | 1 | Debounced trip comparison |
| tripStatus | output | 1 | Sticky confirmed-trip status, also the pending flag |
| tripIrq | output | 1 | Level interrupt request |

## Verification
A wrong filter accumulator shows up on `filtOut` on the clock after the faulty strobe. A wrong debounce count never appears directly at the ports. It shows only as `tripLevel` moving one or more strobes early or late, so the bench counts strobes up to both edges of the window and checks that a matching sample restarts the count. A status latch that fails to hold or to set shows at `tripStatus` and `tripIrq` in the cycle after the event. The bench therefore checks it across the end of ringing, with the interrupt disabled, and on an edge where a set meets a clear.

// File: rtl/rtp_pkg.sv
package rtp_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic step;   // advance the filter by one sample
    logic flush;  // empty the filter (ringing is off)
  } rtpStrobe_t;
endpackage

// File: rtl/rtp_datapath.sv
module rtp_datapath
  import rtp_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int COEF_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  rtpStrobe_t          strb,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [COEF_W-1:0]   filtCoef,
  input  logic [SAMPLE_W-1:0] tripThresh,
  output logic [SAMPLE_W-1:0] filtOut,
  output logic                aboveNext
);
  localparam int DIFF_W = SAMPLE_W + 1;
  localparam int PROD_W = DIFF_W + COEF_W + 1;

  logic [SAMPLE_W-1:0]      filtAcc;
  logic signed [DIFF_W-1:0] diff;
  logic signed [PROD_W-1:0] diffExt;
  logic signed [PROD_W-1:0] coefExt;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] stepVal;
  logic signed [PROD_W-1:0] sumExt;
  logic [SAMPLE_W-1:0]      filtNext;

  always_comb begin
    diff     = $signed({1'b0, sampleData}) - $signed({1'b0, filtAcc});
    diffExt  = PROD_W'(diff);
    coefExt  = $signed({{(PROD_W-COEF_W){1'b0}}, filtCoef});
    prod     = diffExt * coefExt;
    stepVal  = prod >>> COEF_W;
    sumExt   = $signed({{(PROD_W-SAMPLE_W){1'b0}}, filtAcc}) + stepVal;
    filtNext = sumExt[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || strb.flush) begin
      filtAcc <= '0;
    end else if (strb.step) begin
      filtAcc <= filtNext;
    end
  end

  assign filtOut   = filtAcc;
  assign aboveNext = filtNext > tripThresh;

  AST_FILT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    strb.step |-> (sumExt >= 0 && sumExt[PROD_W-1:SAMPLE_W] == '0)); // R2
  AST_FILT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!strb.step && !strb.flush) |=> $stable(filtAcc)); // R2
  AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (rst)
    strb.flush |=> (filtAcc == '0)); // R6
endmodule

// File: rtl/rtp_control.sv
module rtp_control
  import rtp_pkg::*;
#(
  parameter int DEB_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ringActive,
  input  logic             sampleValid,
  input  logic             aboveNext,
  input  logic [DEB_W-1:0] debounceLen,
  input  logic             irqEnable,
  input  logic             statusClear,
  output rtpStrobe_t       strb,
  output logic             tripLevel,
  output logic             tripStatus,
  output logic             tripIrq
);
  logic [DEB_W-1:0] debCnt;
  logic             debLevel;
  logic             windowDone;
  logic             riseNow;
  logic             tripLatched;

  always_comb begin
    strb.step  = ringActive && sampleValid;
    strb.flush = !ringActive;
  end

  assign windowDone = debCnt >= debounceLen;
  assign riseNow    = strb.step && aboveNext && !debLevel && windowDone;

  // Symmetric hold-until-opposite debouncer
  always_ff @(posedge clk) begin
    if (rst || strb.flush) begin
      debCnt   <= '0;
      debLevel <= 1'b0;
    end else if (strb.step) begin
      if (aboveNext == debLevel) begin
        debCnt <= '0;
      end else if (windowDone) begin
        debLevel <= ~debLevel;
        debCnt   <= '0;
      end else begin
        debCnt <= debCnt + 1'b1;
      end
    end
  end

  // Sticky status, doubling as the pending interrupt flag
  always_ff @(posedge clk) begin
    if (rst) begin
      tripLatched <= 1'b0;
    end else if (riseNow) begin
      tripLatched <= 1'b1;
    end else if (statusClear) begin
      tripLatched <= 1'b0;
    end
  end

  assign tripLevel  = debLevel;
  assign tripStatus = tripLatched;
  assign tripIrq    = tripLatched && irqEnable;

  AST_IDLE_LEVEL_LOW: assert property (@(posedge clk) disable iff (rst)
    !ringActive |=> !tripLevel); // R6
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (ringActive && !sampleValid) |=> $stable(tripLevel)); // R4
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (tripStatus && !statusClear) |=> tripStatus); // R7
  AST_RISE_LATCHES: assert property (@(posedge clk) disable iff (rst)
    $rose(tripLevel) |-> tripStatus); // R7
  AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(tripStatus) |-> $past(statusClear)); // R7
endmodule

// File: rtl/ring_trip_detector.sv
module ring_trip_detector
  import rtp_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int COEF_W   = 8,
  parameter int DEB_W    = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ringActive,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [COEF_W-1:0]   filtCoef,
  input  logic [SAMPLE_W-1:0] tripThresh,
  input  logic [DEB_W-1:0]    debounceLen,
  input  logic                irqEnable,
  input  logic                statusClear,
  output logic [SAMPLE_W-1:0] filtOut,
  output logic                tripLevel,
  output logic                tripStatus,
  output logic                tripIrq
);
  rtpStrobe_t strb;
  logic       aboveNext;

  rtp_control #(.DEB_W(DEB_W)) uCtrl (
    .clk(clk), .rst(rst), .ringActive(ringActive), .sampleValid(sampleValid),
    .aboveNext(aboveNext), .debounceLen(debounceLen), .irqEnable(irqEnable),
    .statusClear(statusClear), .strb(strb), .tripLevel(tripLevel),
    .tripStatus(tripStatus), .tripIrq(tripIrq)
  );

  rtp_datapath #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W)) uData (
    .clk(clk), .rst(rst), .strb(strb), .sampleData(sampleData),
    .filtCoef(filtCoef), .tripThresh(tripThresh), .filtOut(filtOut),
    .aboveNext(aboveNext)
  );
endmodule

// File: tb/ring_trip_detector_test.sv
`timescale 1ns/1ps
module ring_trip_detector_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        ringActive, sampleValid, irqEnable, statusClear;
  logic [15:0] sampleData, tripThresh;
  logic [7:0]  filtCoef;
  logic [6:0]  debounceLen;
  logic [15:0] filtOut;
  logic        tripLevel, tripStatus, tripIrq;

  int checks = 0;
  int errors = 0;
  int expY   = 0;

  always #2.5 clk = ~clk;

  ring_trip_detector uut (
    .clk(clk), .rst(rst), .ringActive(ringActive), .sampleValid(sampleValid),
    .sampleData(sampleData), .filtCoef(filtCoef), .tripThresh(tripThresh),
    .debounceLen(debounceLen), .irqEnable(irqEnable), .statusClear(statusClear),
    .filtOut(filtOut), .tripLevel(tripLevel), .tripStatus(tripStatus),
    .tripIrq(tripIrq)
  );

  function automatic int filtModel(int y, int x, int c);
    int p;
    p = (x - y) * c;
    return y + (p >>> 8);
  endfunction

  task automatic checkVal(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic sendSample(input int x, input logic clr = 1'b0);
    @(negedge clk);
    sampleValid = 1'b1;
    sampleData  = 16'(x);
    statusClear = clr;
    @(negedge clk);
    sampleValid = 1'b0;
    statusClear = 1'b0;
    if (ringActive) expY = filtModel(expY, x, int'(filtCoef));
    else expY = 0;
  endtask

  task automatic testReset();
    checkVal("R1", "filtOut", int'(filtOut), 0);
    checkVal("R1", "tripLevel", int'(tripLevel), 0);
    checkVal("R1", "tripStatus", int'(tripStatus), 0);
    checkVal("R1", "tripIrq", int'(tripIrq), 0);
  endtask

  task automatic testFilter();
    ringActive = 1'b1; filtCoef = 8'd64; tripThresh = 16'hFFFF;
    sendSample(1000);
    checkVal("R2", "filter step 1", int'(filtOut), expY);
    sendSample(1000);
    checkVal("R2", "filter step 2", int'(filtOut), expY);
    repeat (3) @(negedge clk);
    checkVal("R2", "hold without strobe", int'(filtOut), expY);
    filtCoef = 8'd200;
    sendSample(300);
    checkVal("R2", "filter falling step", int'(filtOut), expY);
    ringActive = 1'b0;
    sendSample(5000);
    checkVal("R6", "filter empty off ringing", int'(filtOut), 0);
  endtask

  task automatic testDebounce();
    ringActive = 1'b1; filtCoef = 8'd255; tripThresh = 16'd20000;
    debounceLen = 7'd3; irqEnable = 1'b0;
    for (int i = 0; i < 3; i++) begin
      sendSample(40000);
      checkVal("R4", "level before window", int'(tripLevel), 0);
    end
    sendSample(0);
    checkVal("R4", "restart on match", int'(tripLevel), 0);
    for (int i = 0; i < 3; i++) begin
      sendSample(40000);
      checkVal("R4", "level after restart", int'(tripLevel), 0);
    end
    sendSample(40000);
    checkVal("R4", "level on N+1 strobe", int'(tripLevel), 1);
    checkVal("R7", "status set on rise", int'(tripStatus), 1);
    checkVal("R8", "irq masked", int'(tripIrq), 0);
  endtask

  task automatic testRelease();
    for (int i = 0; i < 3; i++) begin
      sendSample(0);
      checkVal("R5", "level held during release", int'(tripLevel), 1);
    end
    sendSample(0);
    checkVal("R5", "level falls on N+1 strobe", int'(tripLevel), 0);
    checkVal("R7", "status sticky after fall", int'(tripStatus), 1);
  endtask

  task automatic testIrq();
    @(negedge clk); irqEnable = 1'b1;
    #1;
    checkVal("R8", "irq after late enable", int'(tripIrq), 1);
    @(negedge clk); statusClear = 1'b1;
    @(negedge clk); statusClear = 1'b0;
    checkVal("R7", "status cleared", int'(tripStatus), 0);
    checkVal("R8", "irq cleared", int'(tripIrq), 0);
  endtask

  task automatic testImmediateAndFlush();
    debounceLen = 7'd0;
    sendSample(40000);
    checkVal("R4", "zero length immediate", int'(tripLevel), 1);
    checkVal("R8", "irq on trip", int'(tripIrq), 1);
    @(negedge clk); ringActive = 1'b0;
    @(negedge clk); expY = 0;
    checkVal("R6", "level cleared off ringing", int'(tripLevel), 0);
    checkVal("R6", "filter cleared off ringing", int'(filtOut), 0);
    checkVal("R7", "status kept off ringing", int'(tripStatus), 1);
    @(negedge clk); statusClear = 1'b1;
    @(negedge clk); statusClear = 1'b0;
    checkVal("R7", "status cleared again", int'(tripStatus), 0);
  endtask

  task automatic testThresholdAndSetWins();
    ringActive = 1'b1; filtCoef = 8'd128; tripThresh = 16'd1000; debounceLen = 7'd0;
    sendSample(2000);
    checkVal("R3", "filter at threshold", int'(filtOut), 1000);
    checkVal("R3", "equal is not above", int'(tripLevel), 0);
    tripThresh = 16'd999;
    sendSample(1000, 1'b1);
    checkVal("R3", "above threshold trips", int'(tripLevel), 1);
    checkVal("R7", "set wins over clear", int'(tripStatus), 1);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; ringActive = 1'b0; sampleValid = 1'b0; sampleData = '0;
    filtCoef = '0; tripThresh = '0; debounceLen = '0; irqEnable = 1'b0;
    statusClear = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testFilter();
    testDebounce();
    testRelease();
    testIrq();
    testImmediateAndFlush();
    testThresholdAndSetWins();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule